// File: doc/BRIEF.md
# Hit-Frame Store with Serial Drain

The block records detector hits during an acquisition window and ships them out afterwards on one serial line. Each clock cycle it sees two discriminator bits for each of 64 channels: one for a low threshold and one for a high threshold. In every cycle of the window where at least one channel fires, it writes one 160-bit frame into a 128-entry store. A frame holds a chip identity byte, the crossing count inside the current window, and a 2-bit status for every channel. Channels that did not fire are stored as well.

After the window closes, the controller pulses a start input. The block then sends every stored frame, oldest first, one bit per clock, with a valid strobe beside the data. A one-cycle done pulse marks the end of the drain, and the store is then emptied. A full flag tells the controller that later triggers are being dropped.

The control states are IDLE, ACQ, LOAD, SHIFT and DONE. The transitions are:
- IDLE→ACQ when the window opens.
- ACQ→IDLE when the window closes.
- IDLE→LOAD when start arrives with frames stored.
- IDLE→DONE when start arrives with the store empty.
- LOAD→SHIFT.
- SHIFT→SHIFT while bits remain. On the last bit of a frame that is not the final one, the next frame is reloaded with no gap.
- SHIFT→DONE after the last bit of the final frame.
- DONE→IDLE.

Top module: `hitframe_store`

## Requirements
- R1: A frame is 160 bits. Bits [159:152] hold the chip identity sampled in the trigger cycle. Bits [151:128] hold the crossing count. Bits [2i+1:2i] hold the status of channel i.
- R2: Channel status is 00 when neither discriminator fires, 01 when only the low one fires, and 11 whenever the high one fires, whatever the low bit is. The value 10 is never stored.
- R3: A frame is written in each cycle where the window input is high and at least one discriminator bit is set. Window cycles with no set bit write nothing.
- R4: The crossing count in a frame equals the number of window-high cycles that came before it in the same window. It restarts at 0 in each new window.
- R5: A start pulse given in IDLE with the window low drains all stored frames in write order. Each frame is sent from bit 159 down to bit 0. The valid strobe is high for every data bit, and there are no gaps between frames.
- R6: The done output is a single-cycle pulse in the cycle right after the last valid bit. With nothing stored, a start pulse gives the done pulse and no valid bits.
- R7: The full flag rises once 128 frames are stored. Triggers that arrive while full are dropped.
- R8: The full flag stays high until the done pulse of a drain. After that pulse the store is empty and the next window starts storing from zero.
- R9: A start pulse given while the window input is high is ignored, and no valid bit appears.
- R10: During and after reset, full, valid, done and serial data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_i | input | 1 | Acquisition window, high while hits may be stored |
| disc_lo_i | input | 64 | Low-threshold discriminator bit per channel |
| disc_hi_i | input | 64 | High-threshold discriminator bit per channel |
| chip_id_i | input | 8 | Chip identity placed in each frame |
| ro_start_i | input | 1 | Request to start draining stored frames |
| sdata_o | output | 1 | Serial frame data, MSB first, 0 when not valid |
| svalid_o | output | 1 | High when sdata_o carries a bit |
| ro_done_o | output | 1 | One-cycle pulse after the last drained bit |
| full_o | output | 1 | Store holds 128 frames |

## Verification
The hardest state to reach is the full store with triggers still arriving. Reaching it takes 128 trigger cycles without a drain, followed by more window cycles that have hits. The stimulus builds this with one long window in which a channel fires on every cycle, running past the limit. The drained stream must then hold exactly 128 frames, with crossing counts 0 to 127. Random windows of mixed length and hit density, several of them per drain, exercise the crossing-count restart and the frame-to-frame reload.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } hfs_state_e;

    // 2-bit channel status: {high fired, any fired}
    function automatic logic [1:0] chan_code(input logic lo, input logic hi);
        return {hi, lo | hi};
    endfunction

endpackage

// File: rtl/hfs_frame_builder.sv
module hfs_frame_builder #(
    parameter int NUM_CH = 64,
    parameter int BCID_W = 24,
    parameter int HDR_W  = 8,
    localparam int FRAME_W = HDR_W + BCID_W + 2 * NUM_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acq_i,
    input  logic [NUM_CH-1:0]  lo_i,
    input  logic [NUM_CH-1:0]  hi_i,
    input  logic [HDR_W-1:0]   hdr_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               any_hit_o
);
    import hfs_pkg::*;

    logic [BCID_W-1:0]   bcid_q;
    logic [2*NUM_CH-1:0] chans;

    // crossing counter: counts window cycles, held at zero outside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcid_q <= '0;
        end else if (acq_i) begin
            bcid_q <= bcid_q + BCID_W'(1);
        end else begin
            bcid_q <= '0;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            chans[2*i +: 2] = chan_code(lo_i[i], hi_i[i]);
        end
        frame_o   = {hdr_i, bcid_q, chans};
        any_hit_o = |(lo_i | hi_i);
    end

endmodule

// File: rtl/hfs_frame_mem.sv
module hfs_frame_mem #(
    parameter int WIDTH = 160,
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            store_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = store_q[rd_addr_i];

endmodule

// File: rtl/hfs_serializer.sv
module hfs_serializer #(
    parameter int WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o
);
    logic [WIDTH-1:0] sh_q;

    // load wins over shift so the next frame follows the last bit directly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= par_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[WIDTH-2:0], 1'b0};
        end
    end

    assign ser_o = valid_i & sh_q[WIDTH-1];

endmodule

// File: rtl/hfs_ctrl.sv
module hfs_ctrl #(
    parameter int DEPTH   = 128,
    parameter int FRAME_W = 160,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int BW = $clog2(FRAME_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_i,
    input  logic          start_i,
    input  logic          any_hit_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          load_o,
    output logic          shift_o,
    output logic          valid_o,
    output logic          done_o,
    output logic          full_o
);
    import hfs_pkg::*;

    hfs_state_e    state_q, state_d;
    logic [CW-1:0] count_q;
    logic [AW-1:0] rd_ptr_q;
    logic [BW-1:0] bit_q;
    logic          last_bit, last_frame, empty;

    assign full_o     = (count_q == CW'(DEPTH));
    assign empty      = (count_q == '0);
    assign last_bit   = (bit_q == '0);
    assign last_frame = (({1'b0, rd_ptr_q} + CW'(1)) == count_q);
    assign wr_addr_o  = count_q[AW-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acq_i) begin
                    state_d = ST_ACQ;
                end else if (start_i) begin
                    state_d = empty ? ST_DONE : ST_LOAD;
                end
            end
            ST_ACQ:   if (!acq_i) state_d = ST_IDLE;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (last_bit && last_frame) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en_o   = 1'b0;
        load_o    = 1'b0;
        shift_o   = 1'b0;
        valid_o   = 1'b0;
        done_o    = 1'b0;
        rd_addr_o = rd_ptr_q;
        unique case (state_q)
            ST_IDLE, ST_ACQ: wr_en_o = acq_i && any_hit_i && !full_o;
            ST_LOAD:         load_o  = 1'b1;
            ST_SHIFT: begin
                shift_o   = 1'b1;
                valid_o   = 1'b1;
                load_o    = last_bit && !last_frame;
                rd_addr_o = rd_ptr_q + AW'(1);
            end
            ST_DONE:         done_o  = 1'b1;
            default:         ;
        endcase
    end

    // occupancy, read pointer and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            rd_ptr_q <= '0;
            bit_q    <= '0;
        end else begin
            if (wr_en_o) begin
                count_q <= count_q + CW'(1);
            end
            unique case (state_q)
                ST_LOAD: bit_q <= BW'(FRAME_W - 1);
                ST_SHIFT: begin
                    if (last_bit) begin
                        bit_q    <= BW'(FRAME_W - 1);
                        rd_ptr_q <= rd_ptr_q + AW'(1);
                    end else begin
                        bit_q <= bit_q - BW'(1);
                    end
                end
                ST_DONE: begin
                    count_q  <= '0;
                    rd_ptr_q <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hitframe_store.sv
module hitframe_store #(
    parameter int NUM_CH = 64,
    parameter int BCID_W = 24,
    parameter int HDR_W  = 8,
    parameter int DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_i,
    input  logic [NUM_CH-1:0] disc_lo_i,
    input  logic [NUM_CH-1:0] disc_hi_i,
    input  logic [HDR_W-1:0]  chip_id_i,
    input  logic              ro_start_i,
    output logic              sdata_o,
    output logic              svalid_o,
    output logic              ro_done_o,
    output logic              full_o
);
    localparam int FRAME_W = HDR_W + BCID_W + 2 * NUM_CH;
    localparam int AW      = $clog2(DEPTH);

    logic [FRAME_W-1:0] frame_w, rd_frame;
    logic               any_hit, wr_en, load, shift;
    logic [AW-1:0]      wr_addr, rd_addr;

    hfs_frame_builder #(.NUM_CH(NUM_CH), .BCID_W(BCID_W), .HDR_W(HDR_W)) builder_i (
        .clk(clk), .rst_n(rst_n), .acq_i(acq_i),
        .lo_i(disc_lo_i), .hi_i(disc_hi_i), .hdr_i(chip_id_i),
        .frame_o(frame_w), .any_hit_o(any_hit)
    );

    hfs_ctrl #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .start_i(ro_start_i),
        .any_hit_i(any_hit), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .rd_addr_o(rd_addr), .load_o(load), .shift_o(shift),
        .valid_o(svalid_o), .done_o(ro_done_o), .full_o(full_o)
    );

    hfs_frame_mem #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) mem_i (
        .clk(clk), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(frame_w),
        .rd_addr_i(rd_addr), .rd_data_o(rd_frame)
    );

    hfs_serializer #(.WIDTH(FRAME_W)) ser_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(shift),
        .valid_i(svalid_o), .par_i(rd_frame), .ser_o(sdata_o)
    );

endmodule

// File: rtl/hfs_checker.sv
module hfs_checker #(
    parameter int NUM_CH  = 64,
    parameter int FRAME_W = 160
) (
    input logic               clk,
    input logic               rst_n,
    input logic               full_o,
    input logic               svalid_o,
    input logic               ro_done_o,
    input logic               wr_en,
    input logic [FRAME_W-1:0] wr_frame
);
    // R7: nothing is written once the store is full
    a_r7_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !wr_en);

    // R8: full persists until a drain finishes
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !ro_done_o) |=> full_o);

    // R8: the drain leaves the store empty
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ro_done_o |=> !full_o);

    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ro_done_o |=> !ro_done_o);

    // R6: done never coincides with a data bit
    a_r6_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(ro_done_o && svalid_o));

    // R2: code 10 never reaches the store
    for (genvar g = 0; g < NUM_CH; g++) begin : g_code
        a_r2_no_code10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (wr_frame[2*g +: 2] != 2'b10));
    end
endmodule

bind hitframe_store hfs_checker #(.NUM_CH(NUM_CH), .FRAME_W(FRAME_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .full_o(full_o), .svalid_o(svalid_o),
    .ro_done_o(ro_done_o), .wr_en(wr_en), .wr_frame(frame_w)
);

// File: tb/hitframe_store_tb_top.sv
`timescale 1ns/1ps
module hitframe_store_tb_top;
    localparam int NCH = 64;
    localparam int FW  = 160;
    localparam int DEP = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           acq_i = 1'b0;
    logic [NCH-1:0] disc_lo_i = '0;
    logic [NCH-1:0] disc_hi_i = '0;
    logic [7:0]     chip_id_i = 8'hA5;
    logic           ro_start_i = 1'b0;
    logic           sdata_o, svalid_o, ro_done_o, full_o;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int win_idx = 0;
    int mcount  = 0;
    logic [FW-1:0] exp_q[$];

    always #5 clk = ~clk;

    hitframe_store dut_i (
        .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .disc_lo_i(disc_lo_i),
        .disc_hi_i(disc_hi_i), .chip_id_i(chip_id_i), .ro_start_i(ro_start_i),
        .sdata_o(sdata_o), .svalid_o(svalid_o), .ro_done_o(ro_done_o), .full_o(full_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                         input logic [FW-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // frame per R1 and R2
    function automatic logic [FW-1:0] model_frame(input logic [7:0] id, input int bc,
                                                  input logic [NCH-1:0] lo, input logic [NCH-1:0] hi);
        logic [FW-1:0] f;
        f = '0;
        f[159:152] = id;
        f[151:128] = 24'(bc);
        for (int c = 0; c < NCH; c++) begin
            if (hi[c])      f[2*c +: 2] = 2'b11;
            else if (lo[c]) f[2*c +: 2] = 2'b01;
            else            f[2*c +: 2] = 2'b00;
        end
        return f;
    endfunction

    // one clock: inputs set at negedge, model follows the sampling edge
    task automatic step(input bit acq, input logic [NCH-1:0] lo, input logic [NCH-1:0] hi,
                        input bit start);
        acq_i = acq; disc_lo_i = lo; disc_hi_i = hi; ro_start_i = start;
        @(posedge clk);
        if (acq && |(lo | hi) && mcount < DEP) begin   // R3, R4, R7
            exp_q.push_back(model_frame(chip_id_i, win_idx, lo, hi));
            mcount++;
        end
        win_idx = acq ? win_idx + 1 : 0;
        @(negedge clk);
        check(full_o == (mcount == DEP), "R7 full flag", FW'(full_o), FW'(mcount == DEP));
        if (!start) check(!svalid_o, "R9 no valid outside drain", FW'(svalid_o), '0);
    endtask

    task automatic drain();
        logic [FW-1:0] cur;
        int nb, total, nexp;
        bit prev_v, got_done;
        nexp = exp_q.size();
        cur = '0; nb = 0; total = 0; prev_v = 0; got_done = 0;
        acq_i = 0; disc_lo_i = '0; disc_hi_i = '0; ro_start_i = 1;
        @(posedge clk);
        @(negedge clk);
        ro_start_i = 0;
        for (int k = 0; k < 30000; k++) begin
            if (ro_done_o) begin
                got_done = 1;
                break;
            end
            if (svalid_o) begin
                if (total > 0) check(prev_v, "R5 no gap between bits", '0, 1);
                cur = {cur[FW-2:0], sdata_o};
                nb++; total++;
                if (nb == FW) begin
                    if (exp_q.size() == 0)
                        check(0, "R5 extra frame", cur, '0);
                    else begin
                        logic [FW-1:0] e;
                        e = exp_q.pop_front();
                        check(cur == e, "R1 R5 frame content/order", cur, e);
                    end
                    nb = 0;
                end
            end else begin
                check(sdata_o == 0, "R5 data low when not valid", FW'(sdata_o), '0);
            end
            prev_v = svalid_o;
            @(posedge clk);
            @(negedge clk);
        end
        check(got_done, "R6 done pulse seen", FW'(got_done), 1);
        check(total == nexp * FW, "R5 bit count", FW'(total), FW'(nexp * FW));
        if (nexp > 0) check(prev_v, "R6 done right after last bit", FW'(prev_v), 1);
        check(exp_q.size() == 0, "R5 all frames drained", FW'(exp_q.size()), '0);
        @(posedge clk);
        @(negedge clk);
        check(!ro_done_o, "R6 done single cycle", FW'(ro_done_o), '0);
        check(!full_o, "R8 empty after done", FW'(full_o), '0);
        mcount = 0;
    endtask

    task automatic rand_window(input int len, input int density);
        for (int i = 0; i < len; i++) begin
            logic [NCH-1:0] lo, hi;
            lo = {$urandom, $urandom};
            hi = {$urandom, $urandom} & {$urandom, $urandom};
            if (density == 0) begin
                lo = lo & {$urandom, $urandom} & {$urandom, $urandom};
                hi = hi & {$urandom, $urandom};
            end
            if ($urandom_range(0, 2) == 0) begin lo = '0; hi = '0; end
            chip_id_i = 8'($urandom);
            step(1, lo, hi, 0);
        end
        step(0, '0, '0, 0);
        step(0, '0, '0, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        // R10: reset state
        repeat (3) begin
            @(negedge clk);
            check(!full_o && !svalid_o && !ro_done_o && !sdata_o, "R10 reset outputs",
                  FW'({full_o, svalid_o, ro_done_o, sdata_o}), '0);
        end
        rst_n = 1;
        @(negedge clk);
        check(!full_o && !svalid_o && !ro_done_o, "R10 after reset",
              FW'({full_o, svalid_o, ro_done_o}), '0);

        // R6: drain with nothing stored
        drain();

        // R3: window without hits writes nothing
        for (int i = 0; i < 10; i++) step(1, '0, '0, 0);
        step(0, '0, '0, 0);
        check(mcount == 0, "R3 no hits no frames", FW'(mcount), '0);
        drain();

        // R2: high-only, low-only and both, R4 first window cycle count
        chip_id_i = 8'h3C;
        step(1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 0);
        step(1, '0, '0, 0);
        step(1, 64'hF0F0_0000_0000_00FF, 64'h00F0_0000_0000_000F, 0);
        step(0, '0, '0, 0);
        // R9: start while window high is ignored
        for (int i = 0; i < 4; i++) step(1, '0, '0, 1);
        step(0, '0, '0, 0);
        step(0, '0, '0, 0);
        check(!svalid_o && !ro_done_o, "R9 start ignored during window",
              FW'({svalid_o, ro_done_o}), '0);
        drain();

        // R4: several windows before one drain, random contents
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < 3; w++) rand_window($urandom_range(3, 20), w % 2);
            drain();
        end

        // R7/R8: fill past the limit in one window
        chip_id_i = 8'h81;
        for (int i = 0; i < DEP + 15; i++)
            step(1, NCH'(1) << (i % NCH), (i % 3 == 0) ? (NCH'(1) << (i % NCH)) : '0, 0);
        step(0, '0, '0, 0);
        check(full_o, "R7 full after fill", FW'(full_o), 1);
        rand_window(8, 1);
        check(full_o, "R8 full persists", FW'(full_o), 1);
        drain();

        // R8: store reusable after drain
        rand_window(12, 1);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule